// File: doc/BRIEF.md
# Masked Raster Position Comparator

This block decides whether a display-list sequencer may leave a beam-wait instruction or take a conditional skip. It receives both halves of the 32-bit instruction, the live vertical and horizontal beam counters and a busy flag from a block-copy engine. It drives one registered flag, `reached`. The flag is true when the beam has arrived at the coded position or gone beyond it. The sequencer ends a wait, or skips the next instruction, when the flag is set.

Only part of the beam position takes part in the comparison. The vertical target has 8 bits and is compared with the low 8 bits of the vertical counter; counter bit 8 is ignored. The horizontal target has 7 bits and is compared with horizontal counter bits 8..2, so horizontal positions step in units of 4. Mask bits in the second word remove individual bits from both the beam and the target operands. A control bit selects whether the result is also held low while the copy engine is busy.

Top module: `beam_wait_cmp`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it goes high, `reached` is 0.
- R2: The vertical target is `word_a[15:8]`. It is compared only with `vpos[7:0]`, and the value of `vpos[8]` has no effect on the result.
- R3: The horizontal target is `word_a[7:1]`. It is compared with `hpos[8:2]`, and `hpos[1:0]` have no effect on the result.
- R4: `word_b[14:8]` mask vertical bits 6..0 and `word_b[7:1]` mask horizontal bits 8..2. A mask bit of 0 removes that bit from both the beam operand and the target operand. Vertical bit 7 has no mask bit and is always compared.
- R5: The two masked values are each formed as vertical bits above horizontal bits. The condition is true when the masked beam value is greater than or equal to the masked target value, and an exact match counts as true.
- R6: When `word_b[15]` is 0 and `copy_busy` is 1, the result is 0 whatever the positions are.
- R7: When `word_b[15]` is 1, `copy_busy` has no effect on the result.
- R8: `reached` is registered. It shows the condition for the inputs that were present at the previous rising clock edge.
- R9: The wait/skip select bit `word_b[0]` has no effect on the result.
- R10: For `word_a` = 0xFFFF and `word_b` = 0xFFFE, `reached` is 0 for every `hpos` up to 0xE4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_a | input | 16 | First instruction word: vertical target [15:8], horizontal target [7:1] |
| word_b | input | 16 | Second instruction word: engine-ignore [15], vertical mask [14:8], horizontal mask [7:1], select [0] |
| vpos | input | 9 | Live vertical beam counter |
| hpos | input | 9 | Live horizontal beam counter |
| copy_busy | input | 1 | Busy flag from the block-copy engine |
| reached | output | 1 | Registered result: the beam has reached the masked target |

## Verification
The end-of-list property assumes that the horizontal counter never goes above 0xE4, as on a real raster. The random stimulus therefore draws `hpos` only from 0 to 0xE4. The random stimulus draws `vpos` from its full 9-bit range, so bit 8 is often set. It draws the instruction words freely, and this also covers the select bit and all mask patterns. The busy-gating property relies on `word_b` and `copy_busy` being sampled at the same edge as the positions. The bench holds every input for a whole clock period and changes it only on the falling edge.

// File: rtl/beam_wait_pkg.sv
package beam_wait_pkg;
   // Instruction word width
   localparam int unsigned WORD_W   = 16;
   // Bit positions in the second word
   localparam int unsigned ENG_IGN_BIT = 15;
   localparam int unsigned SEL_BIT     = 0;

   // Comparator implementation variants
   typedef enum logic [0:0] {
      CMP_DIRECT = 1'b0,
      CMP_RIPPLE = 1'b1
   } cmp_style_e;
endpackage

// File: rtl/wait_field_dec.sv
module wait_field_dec
   import beam_wait_pkg::*;
#(
   parameter int unsigned VCNT_W  = 9,
   parameter int unsigned HCNT_W  = 9,
   parameter int unsigned VPOS_W  = 8,
   parameter int unsigned HPOS_W  = 7,
   localparam int unsigned HSTEP  = HCNT_W - HPOS_W,
   localparam int unsigned VM_W   = VPOS_W - 1,
   localparam int unsigned CMP_W  = VPOS_W + HPOS_W
)(
   input  logic [WORD_W-1:0] word_a,
   input  logic [WORD_W-1:0] word_b,
   input  logic [VCNT_W-1:0] vpos,
   input  logic [HCNT_W-1:0] hpos,
   output logic [CMP_W-1:0]  beam_m,
   output logic [CMP_W-1:0]  tgt_m,
   output logic              eng_ignore
);
   // Elaboration-time checks of the field layout
   if (VM_W + HPOS_W + 2 != WORD_W) begin : g_bad_word_b
      $error("second word fields do not fill the word");
   end
   if (VPOS_W + HPOS_W + 1 != WORD_W) begin : g_bad_word_a
      $error("first word fields do not fill the word");
   end
   if (VPOS_W >= VCNT_W) begin : g_bad_vcnt
      $error("vertical target must be narrower than the counter");
   end
   if (HPOS_W >= HCNT_W) begin : g_bad_hcnt
      $error("horizontal target must be narrower than the counter");
   end

   logic [VPOS_W-1:0] vmask_full;
   logic [HPOS_W-1:0] hmask;
   logic [VPOS_W-1:0] v_tgt;
   logic [HPOS_W-1:0] h_tgt;
   logic [VPOS_W-1:0] v_beam;
   logic [HPOS_W-1:0] h_beam;

   always_comb begin
      // the top vertical bit has no mask bit and is always compared
      vmask_full = {1'b1, word_b[ENG_IGN_BIT-1 -: VM_W]};
      hmask      = word_b[SEL_BIT+1 +: HPOS_W];
      v_tgt      = word_a[WORD_W-1 -: VPOS_W];
      h_tgt      = word_a[1 +: HPOS_W];
      // the counter MSBs above the target width and the low step bits are dropped
      v_beam     = vpos[VPOS_W-1:0];
      h_beam     = hpos[HCNT_W-1 -: HPOS_W];
      beam_m     = {v_beam & vmask_full, h_beam & hmask};
      tgt_m      = {v_tgt  & vmask_full, h_tgt  & hmask};
      eng_ignore = word_b[ENG_IGN_BIT];
   end
endmodule

// File: rtl/masked_ge_cmp.sv
module masked_ge_cmp
   import beam_wait_pkg::*;
#(
   parameter int unsigned W     = 15,
   parameter cmp_style_e  STYLE = CMP_RIPPLE
)(
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         ge
);
   if (W < 1) begin : g_bad_w
      $error("comparator width must be positive");
   end

   if (STYLE == CMP_DIRECT) begin : g_direct
      assign ge = (a >= b);
   end else begin : g_ripple
      // carry chain from LSB: stage i holds a[i:0] >= b[i:0]
      logic [W:0] chain;
      assign chain[0] = 1'b1;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign chain[i+1] = (a[i] & ~b[i]) | (~(a[i] ^ b[i]) & chain[i]);
      end
      assign ge = chain[W];
   end

   // R5
   always_comb begin
      if (a == b) begin
         equal_is_ge_chk: assert (ge);
      end
   end
endmodule

// File: rtl/beam_wait_cmp.sv
module beam_wait_cmp
   import beam_wait_pkg::*;
#(
   parameter int unsigned VCNT_W = 9,
   parameter int unsigned HCNT_W = 9,
   parameter int unsigned VPOS_W = 8,
   parameter int unsigned HPOS_W = 7,
   parameter cmp_style_e  STYLE  = CMP_RIPPLE,
   localparam int unsigned CMP_W = VPOS_W + HPOS_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       word_a,
   input  logic [15:0]       word_b,
   input  logic [VCNT_W-1:0] vpos,
   input  logic [HCNT_W-1:0] hpos,
   input  logic              copy_busy,
   output logic              reached
);
   if (WORD_W != 16) begin : g_bad_pkg
      $error("package word width must match the ports");
   end

   logic [CMP_W-1:0] beam_m;
   logic [CMP_W-1:0] tgt_m;
   logic             eng_ignore;
   logic             pos_ge;
   logic             cond;

   wait_field_dec #(
      .VCNT_W (VCNT_W),
      .HCNT_W (HCNT_W),
      .VPOS_W (VPOS_W),
      .HPOS_W (HPOS_W)
   ) u_dec (
      .word_a     (word_a),
      .word_b     (word_b),
      .vpos       (vpos),
      .hpos       (hpos),
      .beam_m     (beam_m),
      .tgt_m      (tgt_m),
      .eng_ignore (eng_ignore)
   );

   masked_ge_cmp #(
      .W     (CMP_W),
      .STYLE (STYLE)
   ) u_cmp (
      .a  (beam_m),
      .b  (tgt_m),
      .ge (pos_ge)
   );

   assign cond = pos_ge & (eng_ignore | ~copy_busy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reached <= 1'b0;
      else        reached <= cond;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !reached);

   // R6
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!word_b[15] && copy_busy) |=> !reached);

   // R10
   end_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_a == 16'hFFFF && word_b == 16'hFFFE && hpos <= 9'hE4) |=> !reached);

   // R8
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_b[15] && beam_m >= tgt_m) |=> reached);
endmodule

// File: tb/beam_wait_cmp_test.sv
module beam_wait_cmp_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] word_a = '0;
   logic [15:0] word_b = '0;
   logic [8:0]  vpos = '0;
   logic [8:0]  hpos = '0;
   logic        copy_busy = 1'b0;
   logic        reached;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   beam_wait_cmp uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_a    (word_a),
      .word_b    (word_b),
      .vpos      (vpos),
      .hpos      (hpos),
      .copy_busy (copy_busy),
      .reached   (reached)
   );

   function automatic bit model(input logic [15:0] wa, input logic [15:0] wb,
                                input logic [8:0] v, input logic [8:0] h, input logic busy);
      logic [7:0]  vm;
      logic [6:0]  hm;
      logic [14:0] bm, tm;
      vm = {1'b1, wb[14:8]};
      hm = wb[7:1];
      bm = {v[7:0] & vm, h[8:2] & hm};
      tm = {wa[15:8] & vm, wa[7:1] & hm};
      return (bm >= tm) && (wb[15] || !busy);
   endfunction

   task automatic check(input string req, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: reached=%0b expected=%0b", req, got, exp);
      end
   endtask

   // drive on the falling edge, sample shortly after the next rising edge
   task automatic apply(input string req, input logic [15:0] wa, input logic [15:0] wb,
                        input logic [8:0] v, input logic [8:0] h, input logic busy,
                        input logic exp);
      @(negedge clk);
      word_a = wa; word_b = wb; vpos = v; hpos = h; copy_busy = busy;
      @(posedge clk);
      #1;
      check(req, reached, exp);
      check({req, "_model"}, exp, model(wa, wb, v, h, busy));
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1977));
      // R1: reset state
      word_a = 16'h0000; word_b = 16'hFFFE;
      repeat (3) @(posedge clk);
      #1 check("R1", reached, 1'b0);
      @(negedge clk) rst_n = 1'b1;
      #1 check("R1", reached, 1'b0);

      // R2: vpos bit 8 ignored
      apply("R2", 16'h8001, 16'hFFFE, 9'h07F, 9'h000, 1'b0, 1'b0);
      apply("R2", 16'h8001, 16'hFFFE, 9'h17F, 9'h000, 1'b0, 1'b0);
      apply("R2", 16'h8001, 16'hFFFE, 9'h080, 9'h000, 1'b0, 1'b1);
      // R3: hpos[1:0] ignored, hpos[8:2] against word_a[7:1]
      apply("R3", 16'h1021, 16'hFFFE, 9'h010, 9'h03F, 1'b0, 1'b0);
      apply("R3", 16'h1021, 16'hFFFE, 9'h010, 9'h040, 1'b0, 1'b1);
      apply("R3", 16'h1021, 16'hFFFE, 9'h010, 9'h043, 1'b0, 1'b1);
      // R4: masks clear bits in both operands, vertical bit 7 always used
      apply("R4", 16'h7F01, 16'h8000, 9'h000, 9'h000, 1'b0, 1'b1);
      apply("R4", 16'hFF01, 16'h8000, 9'h07F, 9'h000, 1'b0, 1'b0);
      apply("R4", 16'h0F01, 16'h8F00, 9'h0F5, 9'h000, 1'b0, 1'b1);
      apply("R4", 16'h0FFF, 16'h8F02, 9'h00F, 9'h004, 1'b0, 1'b1);
      // R5: vertical dominates, equality counts
      apply("R5", 16'h4051, 16'hFFFE, 9'h040, 9'h0A0, 1'b0, 1'b1);
      apply("R5", 16'h4051, 16'hFFFE, 9'h040, 9'h09C, 1'b0, 1'b0);
      apply("R5", 16'h4051, 16'hFFFE, 9'h041, 9'h000, 1'b0, 1'b1);
      // R6: busy holds result low
      apply("R6", 16'h0001, 16'h7FFE, 9'h0FF, 9'h0E4, 1'b1, 1'b0);
      // R7: busy ignored with control bit set
      apply("R7", 16'h0001, 16'hFFFE, 9'h0FF, 9'h0E4, 1'b1, 1'b1);
      // R9: select bit has no effect
      apply("R9", 16'h4051, 16'hFFFF, 9'h040, 9'h0A0, 1'b0, 1'b1);
      apply("R9", 16'h4051, 16'hFFFF, 9'h040, 9'h09C, 1'b0, 1'b0);
      // R10: end marker never satisfied
      apply("R10", 16'hFFFF, 16'hFFFE, 9'h1FF, 9'h0E4, 1'b0, 1'b0);
      apply("R10", 16'hFFFF, 16'hFFFE, 9'h0FF, 9'h0E3, 1'b1, 1'b0);

      // R8: output changes only at the edge after the inputs change
      apply("R8", 16'h0001, 16'hFFFE, 9'h000, 9'h004, 1'b0, 1'b1);
      @(negedge clk);
      word_a = 16'hFFFF;
      #1 check("R8", reached, 1'b1);
      @(posedge clk);
      #1 check("R8", reached, 1'b0);

      // R5: random mix
      for (int i = 0; i < 400; i++) begin
         logic [15:0] wa, wb;
         logic [8:0]  v, h;
         logic        b;
         wa = 16'($urandom);
         wb = 16'($urandom);
         v  = 9'($urandom);
         h  = 9'($urandom_range(228, 0));
         b  = 1'($urandom);
         apply("R5", wa, wb, v, h, b, model(wa, wb, v, h, b));
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule